// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block is a small instruction cache that sits in the fetch stage of a single-issue pipeline. It is indexed and tagged with the virtual fetch address, so a hit needs no address translation. Each line holds four 32-bit instruction words and its tag, and the whole line is read as one row. The word the program counter selects is put on the instruction output right away, before the tag compare has finished. The hit flag that follows in the same cycle tells the pipeline whether to use that word.

When a fetch misses, the block raises its stall output and asks an external refill port for the missing line. The line comes back as two 64-bit beats, each carrying two instruction words with even parity per byte. Once the second beat has been written, the stall drops and the retried fetch hits. A beat that fails the parity check leaves the line invalid, so the next fetch of that line misses again. A flush input invalidates every line at once and also abandons any refill in progress.

Top module: `ibuf_cache`

## Requirements
- R1: After reset every line is invalid and no refill is requested, so the first fetch misses and raises stall_o.
- R2: When fetch_i is high, no refill is in progress, the indexed line is valid and its tag equals pc_i[31:11], hit_o is high and stall_o is low in the same cycle. instr_o then holds the word at position pc_i[3:2] of that line.
- R3: instr_o always shows the word stored at line pc_i[10:4], word pc_i[3:2]. This holds even when hit_o is low, because the data is speculative.
- R4: A fetch that misses while no refill is in progress raises stall_o in the same cycle. In the following cycle, refill_req_o is high and refill_addr_o equals pc_i with bits [3:0] cleared, unless flush_i was high in the miss cycle.
- R5: The refill takes exactly two beats, and a beat is accepted only in a cycle where both refill_req_o and refill_valid_i are high. Beat 0 carries word 0 in bits [31:0] and word 1 in bits [63:32]. Beat 1 carries words 2 and 3 in the same layout. A refill_valid_i while no refill is requested is ignored.
- R6: refill_req_o, stall_o and refill_addr_o stay unchanged until the second beat is accepted. In the cycle after that beat, refill_req_o is low and the retried fetch hits.
- R7: refill_par_i[k] is the even parity bit of byte k of refill_data_i, meaning the XOR of that byte and its bit is 0. If an accepted beat has a wrong parity bit, refill_perr_o is high in that cycle and the refilled line is left invalid.
- R8: The cache is direct-mapped. A refill replaces whatever line sat at index pc_i[10:4], so two addresses 2 KB apart evict each other.
- R9: flush_i clears every valid bit at the next clock edge. It also ends any refill, so refill_req_o is low in the next cycle, and a miss in the same cycle as the flush starts no refill.
- R10: With fetch_i low and no refill in progress, hit_o and stall_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all lines and abandon a refill |
| fetch_i | input | 1 | A fetch is requested this cycle |
| pc_i | input | 32 | Virtual fetch address |
| instr_o | output | 32 | Speculative instruction word |
| hit_o | output | 1 | instr_o is valid for pc_i |
| stall_o | output | 1 | Fetch must be held and retried |
| refill_req_o | output | 1 | Refill of a line is requested |
| refill_addr_o | output | 32 | Line-aligned address of the requested line |
| refill_valid_i | input | 1 | A refill beat is present |
| refill_data_i | input | 64 | Two instruction words of the beat |
| refill_par_i | input | 8 | Even parity bit for each byte of the beat |
| refill_perr_o | output | 1 | The accepted beat failed the parity check |

## Verification
hit_o, stall_o, instr_o and refill_perr_o are combinational from the inputs and the stored state, so they are due in the cycle the stimulus is driven. refill_req_o and refill_addr_o are due one clock after the miss. A line written by the second beat becomes visible one clock after that beat. The bench drives inputs just after the falling edge and reads outputs 1 ns later, which is well before the next rising edge. It moves exactly one rising edge between a stimulus and each registered result, so every check reads the cycle in which that result is due.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned LINE_WORDS = 4;
    localparam int unsigned NUM_LINES  = 128;
    localparam int unsigned BEAT_W     = 64;

    localparam int unsigned BYTE_OFS   = $clog2(WORD_W / 8);
    localparam int unsigned OFS_W      = $clog2(LINE_WORDS);
    localparam int unsigned IDX_W      = $clog2(NUM_LINES);
    localparam int unsigned TAG_W      = ADDR_W - IDX_W - OFS_W - BYTE_OFS;
    localparam int unsigned LINE_W     = WORD_W * LINE_WORDS;
    localparam int unsigned BEATS      = LINE_W / BEAT_W;
    localparam int unsigned BEAT_CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int unsigned HOLD_W     = LINE_W - BEAT_W;
    localparam int unsigned PAR_W      = BEAT_W / 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fsm_e;

    typedef struct packed {
        fsm_e                    st;
        logic [BEAT_CNT_W-1:0]   beat;
        logic [TAG_W+IDX_W-1:0]  line;
        logic                    perr;
        logic [HOLD_W-1:0]       hold;
        logic [NUM_LINES-1:0]    valid;
    } ctrl_s;
endpackage

// File: rtl/ibuf_parity.sv
module ibuf_parity
    import ibuf_pkg::*;
(
    input  logic [BEAT_W-1:0] data_i,
    input  logic [PAR_W-1:0]  par_i,
    output logic              ok_o
);
    logic [PAR_W-1:0] bad;

    for (genvar k = 0; k < PAR_W; k++) begin : g_byte
        assign bad[k] = ^{data_i[8*k +: 8], par_i[k]};
    end

    assign ok_o = ~|bad;
endmodule

// File: rtl/ibuf_store.sv
module ibuf_store
    import ibuf_pkg::*;
(
    input  logic              clk_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [LINE_W-1:0] rd_line_o,
    output logic [TAG_W-1:0]  rd_tag_o,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [LINE_W-1:0] wr_line_i,
    input  logic [TAG_W-1:0]  wr_tag_i
);
    // One row per line: the data words and the tag are read together.
    logic [LINE_W-1:0] data_q [NUM_LINES];
    logic [TAG_W-1:0]  tag_q  [NUM_LINES];

    always_ff @(posedge clk_i) begin
        if (wr_en_i) begin
            data_q[wr_idx_i] <= wr_line_i;
            tag_q[wr_idx_i]  <= wr_tag_i;
        end
    end

    assign rd_line_o = data_q[rd_idx_i];
    assign rd_tag_o  = tag_q[rd_idx_i];
endmodule

// File: rtl/ibuf_ctrl.sv
module ibuf_ctrl
    import ibuf_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    flush_i,
    input  logic                    fetch_i,
    input  logic [TAG_W-1:0]        pc_tag_i,
    input  logic [IDX_W-1:0]        pc_idx_i,
    input  logic [TAG_W-1:0]        rd_tag_i,
    input  logic                    beat_valid_i,
    input  logic [BEAT_W-1:0]       beat_data_i,
    input  logic                    beat_ok_i,
    output logic                    hit_o,
    output logic                    stall_o,
    output logic                    req_o,
    output logic [TAG_W+IDX_W-1:0]  req_line_o,
    output logic                    perr_o,
    output logic                    wr_en_o,
    output logic [IDX_W-1:0]        wr_idx_o,
    output logic [TAG_W-1:0]        wr_tag_o,
    output logic [LINE_W-1:0]       wr_line_o
);
    ctrl_s q, d;
    logic  idle, miss, take, last;

    assign idle = (q.st == ST_IDLE);
    assign hit_o   = fetch_i && idle && q.valid[pc_idx_i] && (rd_tag_i == pc_tag_i);
    assign miss    = fetch_i && idle && !hit_o;
    assign stall_o = miss || !idle;
    assign take    = !idle && beat_valid_i;
    assign last    = (q.beat == BEAT_CNT_W'(BEATS - 1));

    assign req_o      = !idle;
    assign req_line_o = q.line;
    assign perr_o     = take && !beat_ok_i;
    assign wr_idx_o   = q.line[IDX_W-1:0];
    assign wr_tag_o   = q.line[TAG_W+IDX_W-1:IDX_W];
    assign wr_line_o  = {beat_data_i, q.hold};

    always_comb begin
        d       = q;
        wr_en_o = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (miss && !flush_i) begin
                    d.st   = ST_FILL;
                    d.beat = '0;
                    d.line = {pc_tag_i, pc_idx_i};
                    d.perr = 1'b0;
                end
            end
            default: begin
                if (take) begin
                    if (!beat_ok_i) d.perr = 1'b1;
                    if (last) begin
                        wr_en_o = !flush_i;
                        d.st    = ST_IDLE;
                    end else begin
                        d.hold[q.beat*BEAT_W +: BEAT_W] = beat_data_i;
                        d.beat = q.beat + 1'b1;
                    end
                end
            end
        endcase
        if (flush_i) begin
            d.valid = '0;
            d.st    = ST_IDLE;
        end else if (wr_en_o) begin
            d.valid[q.line[IDX_W-1:0]] = !(q.perr || !beat_ok_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/ibuf_cache.sv
module ibuf_cache
    import ibuf_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic              fetch_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic [WORD_W-1:0] instr_o,
    output logic              hit_o,
    output logic              stall_o,
    output logic              refill_req_o,
    output logic [ADDR_W-1:0] refill_addr_o,
    input  logic              refill_valid_i,
    input  logic [BEAT_W-1:0] refill_data_i,
    input  logic [PAR_W-1:0]  refill_par_i,
    output logic              refill_perr_o
);
    localparam int unsigned IDX_LO = OFS_W + BYTE_OFS;

    logic [TAG_W-1:0]       pc_tag, rd_tag, wr_tag;
    logic [IDX_W-1:0]       pc_idx, wr_idx;
    logic [OFS_W-1:0]       pc_ofs;
    logic [LINE_W-1:0]      rd_line, wr_line;
    logic [TAG_W+IDX_W-1:0] req_line;
    logic                   wr_en, beat_ok;

    assign pc_tag = pc_i[ADDR_W-1 -: TAG_W];
    assign pc_idx = pc_i[IDX_LO +: IDX_W];
    assign pc_ofs = pc_i[BYTE_OFS +: OFS_W];

    ibuf_store u_store (
        .clk_i     (clk_i),
        .rd_idx_i  (pc_idx),
        .rd_line_o (rd_line),
        .rd_tag_o  (rd_tag),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_line_i (wr_line),
        .wr_tag_i  (wr_tag)
    );

    ibuf_parity u_par (
        .data_i (refill_data_i),
        .par_i  (refill_par_i),
        .ok_o   (beat_ok)
    );

    ibuf_ctrl u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .flush_i      (flush_i),
        .fetch_i      (fetch_i),
        .pc_tag_i     (pc_tag),
        .pc_idx_i     (pc_idx),
        .rd_tag_i     (rd_tag),
        .beat_valid_i (refill_valid_i),
        .beat_data_i  (refill_data_i),
        .beat_ok_i    (beat_ok),
        .hit_o        (hit_o),
        .stall_o      (stall_o),
        .req_o        (refill_req_o),
        .req_line_o   (req_line),
        .perr_o       (refill_perr_o),
        .wr_en_o      (wr_en),
        .wr_idx_o     (wr_idx),
        .wr_tag_o     (wr_tag),
        .wr_line_o    (wr_line)
    );

    // Speculative word: chosen from the row before the tag compare settles.
    assign instr_o       = rd_line[pc_ofs*WORD_W +: WORD_W];
    assign refill_addr_o = {req_line, {IDX_LO{1'b0}}};
endmodule

// File: rtl/ibuf_cache_chk.sv
module ibuf_cache_chk
    import ibuf_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              flush_i,
    input logic              fetch_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic [WORD_W-1:0] instr_o,
    input logic              hit_o,
    input logic              stall_o,
    input logic              refill_req_o,
    input logic [ADDR_W-1:0] refill_addr_o,
    input logic              refill_valid_i,
    input logic [BEAT_W-1:0] refill_data_i,
    input logic [PAR_W-1:0]  refill_par_i,
    input logic              refill_perr_o
);
    assert_hit_no_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> (fetch_i && !stall_o && !refill_req_o));

    assert_miss_requests_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!refill_req_o && fetch_i && !hit_o && !flush_i) |=> refill_req_o);

    assert_req_stalls_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        refill_req_o |-> stall_o);

    assert_req_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (refill_req_o && !refill_valid_i && !flush_i) |=> (refill_req_o && $stable(refill_addr_o)));

    assert_perr_in_beat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        refill_perr_o |-> (refill_req_o && refill_valid_i));

    assert_flush_ends_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> !refill_req_o);

    assert_quiet_when_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fetch_i && !refill_req_o) |-> (!stall_o && !hit_o));
endmodule

bind ibuf_cache ibuf_cache_chk u_chk (.*);

// File: tb/sim_ibuf_cache.sv
module sim_ibuf_cache;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        flush_i = 1'b0;
    logic        fetch_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic [31:0] instr_o;
    logic        hit_o, stall_o, refill_req_o, refill_perr_o;
    logic [31:0] refill_addr_o;
    logic        refill_valid_i = 1'b0;
    logic [63:0] refill_data_i = '0;
    logic [7:0]  refill_par_i = '0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk_i = ~clk_i;

    ibuf_cache u0 (.*);

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC0DE_0000;
    endfunction

    function automatic logic [7:0] par_of(input logic [63:0] v);
        logic [7:0] p;
        for (int k = 0; k < 8; k++) p[k] = ^v[8*k +: 8];
        return p;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic drive_fetch(input logic f, input logic [31:0] pc);
        fetch_i = f;
        pc_i    = pc;
        #1;
    endtask

    // Called at a falling edge right after a missing fetch has been driven.
    task automatic fill_line(input logic [31:0] pc, input int bad_beat, input bit gap);
        logic [31:0] base;
        logic [63:0] dat;
        base = {pc[31:4], 4'b0};
        step();
        check("R4 req after miss", refill_req_o, 1'b1);
        check("R4 refill address", refill_addr_o, base);
        for (int b = 0; b < 2; b++) begin
            if (gap && b == 1) begin
                refill_valid_i = 1'b0;
                step();
                check("R6 req held over gap", refill_req_o, 1'b1);
                check("R6 stall held over gap", stall_o, 1'b1);
                check("R6 addr held over gap", refill_addr_o, base);
            end
            dat = {mem_word(base + 32'(8*b + 4)), mem_word(base + 32'(8*b))};
            refill_valid_i = 1'b1;
            refill_data_i  = dat;
            refill_par_i   = par_of(dat) ^ ((b == bad_beat) ? 8'h10 : 8'h00);
            #1;
            check("R7 parity flag", refill_perr_o, (b == bad_beat) ? 1'b1 : 1'b0);
            check("R6 stall during refill", stall_o, 1'b1);
            step();
            refill_valid_i = 1'b0;
        end
        #1;
        check("R6 req low after last beat", refill_req_o, 1'b0);
    endtask

    task automatic t_reset();
        drive_fetch(1'b0, 32'h0);
        check("R1 no req after reset", refill_req_o, 1'b0);
        check("R10 no stall idle", stall_o, 1'b0);
        drive_fetch(1'b1, 32'h0000_0100);
        check("R1 first fetch misses", hit_o, 1'b0);
        check("R1 first fetch stalls", stall_o, 1'b1);
        fill_line(32'h0000_0100, -1, 1'b0);
        check("R6 retried fetch hits", hit_o, 1'b1);
    endtask

    task automatic t_basic();
        drive_fetch(1'b1, 32'h0000_1238);
        check("R4 miss stall", stall_o, 1'b1);
        fill_line(32'h0000_1238, -1, 1'b0);
        for (int w = 0; w < 4; w++) begin
            drive_fetch(1'b1, 32'h0000_1230 + 32'(4*w));
            check("R2 hit in line", hit_o, 1'b1);
            check("R2 no stall on hit", stall_o, 1'b0);
            check("R5 word layout", instr_o, mem_word(32'h0000_1230 + 32'(4*w)));
        end
    endtask

    task automatic t_gap();
        drive_fetch(1'b1, 32'h0000_2044);
        fill_line(32'h0000_2044, -1, 1'b1);
        drive_fetch(1'b1, 32'h0000_204C);
        check("R6 hit after gap refill", hit_o, 1'b1);
        check("R5 word 3 after gap", instr_o, mem_word(32'h0000_204C));
    endtask

    task automatic t_conflict();
        drive_fetch(1'b1, 32'h0000_1A34);
        check("R8 conflict misses", hit_o, 1'b0);
        check("R3 speculative old word", instr_o, mem_word(32'h0000_1234));
        fill_line(32'h0000_1A34, -1, 1'b0);
        check("R8 new line hits", hit_o, 1'b1);
        drive_fetch(1'b1, 32'h0000_1234);
        check("R8 old line evicted", hit_o, 1'b0);
        check("R3 speculative new word", instr_o, mem_word(32'h0000_1A34));
        fill_line(32'h0000_1234, -1, 1'b0);
        check("R8 old line back", instr_o, mem_word(32'h0000_1234));
    endtask

    task automatic t_parity();
        drive_fetch(1'b1, 32'h0000_3000);
        fill_line(32'h0000_3000, 1, 1'b0);
        check("R7 bad line left invalid", hit_o, 1'b0);
        check("R7 bad line stalls", stall_o, 1'b1);
        fill_line(32'h0000_3000, 0, 1'b0);
        check("R7 bad first beat invalid", hit_o, 1'b0);
        fill_line(32'h0000_3000, -1, 1'b0);
        check("R7 clean refill hits", hit_o, 1'b1);
    endtask

    task automatic t_flush();
        drive_fetch(1'b0, 32'h0000_1234);
        flush_i = 1'b1;
        step();
        flush_i = 1'b0;
        drive_fetch(1'b1, 32'h0000_1234);
        check("R9 flushed line misses", hit_o, 1'b0);
        flush_i = 1'b1;
        step();
        flush_i = 1'b0;
        #1;
        check("R9 miss with flush no req", refill_req_o, 1'b0);
        step();
        check("R4 req after plain miss", refill_req_o, 1'b1);
        flush_i = 1'b1;
        step();
        flush_i = 1'b0;
        drive_fetch(1'b0, 32'h0000_1234);
        check("R9 flush ends refill", refill_req_o, 1'b0);
        check("R10 idle no stall", stall_o, 1'b0);
        check("R10 idle no hit", hit_o, 1'b0);
    endtask

    task automatic t_ignored_beat();
        drive_fetch(1'b1, 32'h0000_0500);
        fill_line(32'h0000_0500, -1, 1'b0);
        drive_fetch(1'b0, 32'h0000_0500);
        refill_valid_i = 1'b1;
        refill_data_i  = 64'hDEAD_BEEF_DEAD_BEEF;
        refill_par_i   = 8'hFF;
        #1;
        check("R5 no perr outside refill", refill_perr_o, 1'b0);
        step();
        refill_valid_i = 1'b0;
        step();
        check("R5 stray beat no req", refill_req_o, 1'b0);
        drive_fetch(1'b1, 32'h0000_0508);
        check("R5 line kept hit", hit_o, 1'b1);
        check("R5 line kept data", instr_o, mem_word(32'h0000_0508));
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_basic();
        t_gap();
        t_conflict();
        t_parity();
        t_flush();
        t_ignored_beat();
        drive_fetch(1'b0, 32'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule